// File: doc/BRIEF.md
# Flag-Producing Barrel Shift Unit

A purely combinational 32-bit shift unit for an integer execution stage. It does logical left, logical right and arithmetic right shifts. Each kind comes in two forms. In the immediate form the count comes from the five-bit shift-amount field of the instruction word. In the register form the count comes from the low five bits of a register operand. The result has the same width as the operand. Bits pushed past either end are dropped.

Besides the result, the unit produces three flags. The carry flag holds the final bit that left the 32-bit field. The zero flag is set when the result is all zeros. The overflow flag is held low for every shift. An unused operation code passes the operand through and clears all three flags.

Top module: `shift_unit`

## Requirements
- R1: Select 0 (left, immediate) and select 4 (left, register) move the operand toward bit 31 by the count, put 0 into the vacated low bits, and drop the bits that pass bit 31.
- R2: Select 1 (logical right, immediate) and select 5 (logical right, register) move the operand toward bit 0 by the count and put 0 into the vacated high bits.
- R3: Select 2 (arithmetic right, immediate) and select 6 (arithmetic right, register) move the operand toward bit 0 and fill the vacated high bits with copies of operand bit 31.
- R4: For a left shift by n (1 to 31), the carry flag equals operand bit 32-n.
- R5: For a right shift, logical or arithmetic, by n (1 to 31), the carry flag equals operand bit n-1.
- R6: With a count of 0 on any valid select, the result equals the operand and the carry flag is 0.
- R7: Selects 0 to 2 take the count from instruction bits 10:6. The register-amount input has no effect on them.
- R8: Selects 4 to 6 take the count from bits 4:0 of the register-amount input. Bits 31:5 of that input and the whole instruction word have no effect on them.
- R9: For selects 0-2 and 4-6, the zero flag is 1 exactly when the 32-bit result is all zeros.
- R10: The overflow flag is 0 for every select and every input.
- R11: Selects 3 and 7 give a result equal to the operand, with carry, zero and overflow flags all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sel_i | input | 3 | Operation select code |
| src_i | input | 32 | Operand to be shifted |
| rs_val_i | input | 32 | Register-supplied shift amount (low 5 bits used) |
| insn_i | input | 32 | Instruction word; bits 10:6 give the immediate count |
| res_o | output | 32 | Shifted result |
| cf_o | output | 1 | Carry flag: last bit shifted out |
| of_o | output | 1 | Overflow flag, always 0 |
| zf_o | output | 1 | Zero flag |

## Verification
The bench runs every select code against every count from 0 to 31 and adds random operands. It also targets the following corner cases:

- **Count zero.** A design that indexes the carry bit as n-1 or 32-n would read a bit outside the field here and report a stray carry.
- **Negative operand, arithmetic right shift.** Sign fill is checked against a zero-filling design, whose high result bits would come out wrong.
- **Left shift by 31 and right shift by 31.** These confirm the carry comes from bit 1 and bit 30. An off-by-one in the barrel would move the carry to a neighbouring bit.
- **Mixed-up count sources.** Garbage is placed in the unused upper register bits and in the instruction field that should be ignored. A design that used the wrong count source, or more than five register bits, would shift by the wrong amount.

// File: rtl/shift_pkg.sv
// Package: shared operation codes and sizing for the shift unit.
// Assumes the data width is a power of two so the count is log2 wide.
package shift_pkg;
    typedef enum logic [2:0] {
        SEL_SLL_IMM = 3'd0,
        SEL_SRL_IMM = 3'd1,
        SEL_SRA_IMM = 3'd2,
        SEL_NOP_A   = 3'd3,
        SEL_SLL_REG = 3'd4,
        SEL_SRL_REG = 3'd5,
        SEL_SRA_REG = 3'd6,
        SEL_NOP_B   = 3'd7
    } shift_sel_e;

    typedef struct packed {
        logic valid;
        logic left;
        logic arith;
        logic use_reg;
    } shift_ctl_t;
endpackage

// File: rtl/shift_decode.sv
// Module: shift_decode
// Turns the 3-bit select into direction, fill kind and count source.
// Assumes codes 3 and 7 are unused and marks them invalid (pass-through).
module shift_decode
    import shift_pkg::*;
(
    input  logic [2:0]  sel_i,
    output shift_ctl_t  ctl_o
);
    // Purpose: map each select code onto the control fields.
    always_comb begin
        ctl_o = '0;
        case (shift_sel_e'(sel_i))
            SEL_SLL_IMM: ctl_o = '{valid: 1'b1, left: 1'b1, arith: 1'b0, use_reg: 1'b0};
            SEL_SRL_IMM: ctl_o = '{valid: 1'b1, left: 1'b0, arith: 1'b0, use_reg: 1'b0};
            SEL_SRA_IMM: ctl_o = '{valid: 1'b1, left: 1'b0, arith: 1'b1, use_reg: 1'b0};
            SEL_SLL_REG: ctl_o = '{valid: 1'b1, left: 1'b1, arith: 1'b0, use_reg: 1'b1};
            SEL_SRL_REG: ctl_o = '{valid: 1'b1, left: 1'b0, arith: 1'b0, use_reg: 1'b1};
            SEL_SRA_REG: ctl_o = '{valid: 1'b1, left: 1'b0, arith: 1'b1, use_reg: 1'b1};
            default:     ctl_o = '0;
        endcase
    end
endmodule

// File: rtl/shift_barrel.sv
// Module: shift_barrel
// Logarithmic right-shift barrel, one bit wider than the data. The extra
// low bit catches whatever leaves the field, so after the last stage it
// holds the last bit shifted out. A left shift reverses the bits before and
// after the barrel.
// Assumes DATA_W is a power of two.
module shift_barrel #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]         din_i,
    input  logic [$clog2(DATA_W)-1:0] cnt_i,
    input  logic                      left_i,
    input  logic                      arith_i,
    output logic [DATA_W-1:0]         dout_o,
    output logic                      last_o
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam int EXT_W = DATA_W + 1;

    logic [DATA_W-1:0] din_rev;
    logic [DATA_W-1:0] right_res;
    logic [DATA_W-1:0] right_rev;
    logic [EXT_W-1:0]  stage [0:CNT_W];
    logic              fill;

    // Purpose: bit-reverse the input and the barrel output for left shifts.
    for (genvar b = 0; b < DATA_W; b++) begin : g_rev
        assign din_rev[b]   = din_i[DATA_W-1-b];
        assign right_rev[b] = right_res[DATA_W-1-b];
    end

    assign fill     = arith_i & ~left_i & din_i[DATA_W-1];
    assign stage[0] = {(left_i ? din_rev : din_i), 1'b0};

    // Purpose: each stage moves the data right by 2**s when count bit s is set.
    for (genvar s = 0; s < CNT_W; s++) begin : g_stage
        localparam int K = 1 << s;
        assign stage[s+1] = cnt_i[s] ? {{K{fill}}, stage[s][EXT_W-1:K]} : stage[s];
    end

    assign right_res = stage[CNT_W][EXT_W-1:1];
    assign dout_o    = left_i ? right_rev : right_res;
    assign last_o    = stage[CNT_W][0];

    // Purpose: a zero count must leave the data intact and catch no bit.
    always_comb begin
        if (cnt_i == '0) begin
            assert_zero_count_R6: assert (dout_o == din_i && !last_o)
                else $error("zero count altered data or carry");
        end
    end

    // Purpose: top bit of a right shift is the sign copy or zero (R2 too).
    always_comb begin
        if (!left_i && cnt_i != '0) begin
            assert_msb_fill_R3: assert (dout_o[DATA_W-1] == (arith_i & din_i[DATA_W-1]))
                else $error("wrong high fill on right shift");
        end
    end
endmodule

// File: rtl/shift_unit.sv
// Module: shift_unit (top)
// Combinational shifter with carry, overflow and zero flags. Picks the count
// from the instruction's shift-amount field or from a register operand.
// Assumes the immediate field sits at SHAMT_LSB and is log2(DATA_W) wide.
module shift_unit
    import shift_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int INSN_W    = 32,
    parameter int SHAMT_LSB = 6
) (
    input  logic [2:0]        sel_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic [DATA_W-1:0] rs_val_i,
    input  logic [INSN_W-1:0] insn_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cf_o,
    output logic              of_o,
    output logic              zf_o
);
    localparam int CNT_W = $clog2(DATA_W);

    shift_ctl_t        ctl;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] shifted;
    logic              last_bit;
    logic              unused_bits;

    shift_decode u_decode (
        .sel_i (sel_i),
        .ctl_o (ctl)
    );

    // Purpose: choose the count source before the barrel.
    assign cnt = ctl.use_reg ? rs_val_i[CNT_W-1:0] : insn_i[SHAMT_LSB +: CNT_W];

    shift_barrel #(.DATA_W(DATA_W)) u_barrel (
        .din_i   (src_i),
        .cnt_i   (cnt),
        .left_i  (ctl.left),
        .arith_i (ctl.arith),
        .dout_o  (shifted),
        .last_o  (last_bit)
    );

    // Purpose: form the result and flags; invalid codes pass the operand.
    always_comb begin
        res_o = ctl.valid ? shifted : src_i;
        cf_o  = ctl.valid & last_bit;
        of_o  = 1'b0;
        zf_o  = ctl.valid & (shifted == '0);
    end

    assign unused_bits = ^{rs_val_i[DATA_W-1:CNT_W], insn_i};

    // Purpose: unused codes leave the operand untouched with flags clear.
    always_comb begin
        if (!ctl.valid) begin
            assert_passthru_R11: assert (res_o == src_i && !cf_o && !zf_o && !of_o)
                else $error("pass-through code changed data or flags");
        end
    end

    // Purpose: a nonzero left shift always puts 0 into bit 0.
    always_comb begin
        if (ctl.valid && ctl.left && cnt != '0) begin
            assert_low_fill_R1: assert (res_o[0] == 1'b0)
                else $error("left shift did not zero-fill");
        end
    end

    // Purpose: logical shifts can only lose ones, never create them.
    always_comb begin
        if (ctl.valid && !ctl.arith) begin
            assert_no_new_ones_R2: assert ($countones(res_o) <= $countones(src_i))
                else $error("logical shift created ones");
        end
    end
endmodule

// File: tb/test_shift_unit.sv
module test_shift_unit;
    logic        clk = 1'b0;
    logic [2:0]  sel;
    logic [31:0] src, rsv, insn;
    logic [31:0] res;
    logic        cf, of, zf;
    int          checks = 0;
    int          errors = 0;
    bit          done   = 1'b0;

    always #2 clk = ~clk;

    shift_unit i_shift_unit (
        .sel_i(sel), .src_i(src), .rs_val_i(rsv), .insn_i(insn),
        .res_o(res), .cf_o(cf), .of_o(of), .zf_o(zf)
    );

    function automatic int count_of(input logic [2:0] s, input logic [31:0] r, input logic [31:0] i);
        return (s >= 3'd4) ? int'(r[4:0]) : int'(i[10:6]);
    endfunction

    function automatic logic [31:0] exp_res(input logic [2:0] s, input logic [31:0] a, input int n);
        case (s)
            3'd0, 3'd4: return a << n;
            3'd1, 3'd5: return a >> n;
            3'd2, 3'd6: return 32'($signed(a) >>> n);
            default:    return a;
        endcase
    endfunction

    function automatic logic exp_cf(input logic [2:0] s, input logic [31:0] a, input int n);
        if (n == 0 || s == 3'd3 || s == 3'd7) return 1'b0;
        if (s == 3'd0 || s == 3'd4) return a[32-n];
        return a[n-1];
    endfunction

    function automatic string res_tag(input logic [2:0] s);
        case (s)
            3'd0, 3'd4: return "R1";
            3'd1, 3'd5: return "R2";
            3'd2, 3'd6: return "R3";
            default:    return "R11";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: sel=%0d src=%h rs=%h insn=%h actual=%h expected=%h",
                     req, sel, src, rsv, insn, act, exp);
        end
    endtask

    task automatic apply_and_check(input logic [2:0] s, input logic [31:0] a,
                                   input logic [31:0] r, input logic [31:0] i, input string extra);
        int n;
        logic [31:0] e;
        @(posedge clk);
        sel = s; src = a; rsv = r; insn = i;
        @(negedge clk);
        n = count_of(s, r, i);
        e = exp_res(s, a, n);
        check(res_tag(s), res, e);
        if (s == 3'd3 || s == 3'd7) begin
            check("R11", {29'd0, cf, zf, of}, 32'd0);
        end else begin
            check(n == 0 ? "R6" : ((s == 3'd0 || s == 3'd4) ? "R4" : "R5"),
                  {31'd0, cf}, {31'd0, exp_cf(s, a, n)});
            check("R9", {31'd0, zf}, {31'd0, e == 32'd0});
        end
        check("R10", {31'd0, of}, 32'd0);
        if (extra != "") check(extra, res, e);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] a, r, i;
        void'($urandom(32'd1234));
        sel = 3'd3; src = 32'hA5A5_0F0F; rsv = '0; insn = '0;
        @(negedge clk);
        check("R11", res, 32'hA5A5_0F0F);
        check("R11", {29'd0, cf, zf, of}, 32'd0);

        // Directed corners.
        apply_and_check(3'd2, 32'h8000_0001, 32'd0, 32'd31 << 6, "R3");
        apply_and_check(3'd0, 32'hFFFF_FFFD, 32'd0, 32'd31 << 6, "R4");
        apply_and_check(3'd1, 32'h4000_0000, 32'd0, 32'd31 << 6, "R5");
        apply_and_check(3'd6, 32'hF000_0000, 32'hFFFF_FFE0, 32'hFFFF_FFFF, "R6");
        apply_and_check(3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd5 << 6, "R7");
        apply_and_check(3'd4, 32'h0000_0003, 32'hABCD_EF03, 32'hFFFF_FFFF, "R8");
        apply_and_check(3'd5, 32'h0000_0001, 32'h0000_0021, 32'd0, "R9");
        apply_and_check(3'd7, 32'h0000_0000, 32'd7, 32'd7 << 6, "R11");

        // Every select against every count.
        for (int s = 0; s < 8; s++) begin
            for (int n = 0; n < 32; n++) begin
                a = $urandom();
                r = ($urandom() & 32'hFFFF_FFE0) | 32'(n);
                i = ($urandom() & ~(32'h1F << 6)) | (32'(n) << 6);
                apply_and_check(3'(s), a, r, i, s >= 4 ? "R8" : "R7");
            end
        end

        // Random mixture.
        for (int k = 0; k < 1500; k++) begin
            a = $urandom();
            if (k % 4 == 0) a = {a[31], 31'd0};
            apply_and_check(3'($urandom()), a, $urandom(), $urandom(), "");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule